// File: doc/BRIEF.md
# Character Display Instruction Engine

This block carries out the instruction set of a text-mode character display controller against two on-chip stores. One is an 80-cell display store holding character codes. The other is a 64-byte glyph store holding user-defined dot patterns. Any host-side front end can feed it: a serial slave, a parallel bus adapter or a test harness. Each byte the front end delivers is tagged as a command, a data write or a data read.

The block keeps the address pointer and the entry direction. It also keeps the automatic-shift enable, the display window offset, the display, cursor and blink enables, and the line-count, font-height and bus-width settings. All of these are driven out as plain state ports for a downstream scan-out stage. A peek port reads either store by physical index, so that stage or a bench can fetch cell contents.

Requests enter on a valid/ready channel:
- `in_ready` is high exactly when the engine is idle.
- A request is taken on a rising clock edge where both `in_valid` and `in_ready` are high.
- A front end holding `in_valid` while `in_ready` is low is simply stalled, and nothing is lost.
- Read results leave on a one-cycle `rd_valid` pulse that has no back-pressure.

After reset the engine fills the display store with blanks while holding busy, then starts accepting requests.

Top module: `lcd_exec_core`

## Requirements
- R1: After reset, `busy` stays high for 80 cycles while every display cell is filled with 0x20. The state then reads: pointer 0, increment direction, automatic shift off, display/cursor/blink off, one-line mode, short font, 8-bit bus flag set, window offset 0.
- R2: `in_ready` equals `!busy`. An accepted request other than clear holds `busy` for exactly EXEC_CYC cycles after the accepting edge.
- R3: Command 0x01 (clear) writes 0x20 into all 80 display cells, holding `busy` for 80 cycles. It also sets the pointer to 0, selects the display store, forces increment direction and zeroes the window offset.
- R4: A command whose highest set bit is bit 1 (home) zeroes the pointer and the window offset, selects the display store and leaves every cell unchanged.
- R5: Command decode goes by highest set bit:
  - bit 2 is entry mode: bit 1 is the direction, 1 meaning increment; bit 0 is automatic shift.
  - bit 3 is display control: bit 2 display, bit 1 cursor, bit 0 blink.
  - bit 5 is function set: bit 4 bus width, bit 3 two lines, bit 2 tall font.
- R6: Every data write or read moves the pointer by one in the entry direction. In the glyph store the 6-bit pointer wraps between 0x3F and 0x00.
- R7: In one-line mode the display pointer covers 0x00 to 0x4F and wraps from 0x4F to 0x00 and from 0x00 to 0x4F. Address a sits in physical cell a.
- R8: In two-line mode line 1 is 0x00 to 0x27 and line 2 is 0x40 to 0x67. Stepping runs 0x27 to 0x40 and 0x67 to 0x00, and the reverse when decrementing. Line 2 address 0x40+k sits in physical cell 40+k.
- R9: With automatic shift on, each display-store write moves the window offset. Increment direction adds one; decrement direction subtracts one. The offset wraps within 0 to 39 in two-line mode and 0 to 79 in one-line mode. Reads and glyph-store writes never move it.
- R10: For a command whose highest set bit is bit 4, bit 3 chooses a display shift (1) or a cursor move (0), and bit 2 chooses right (1) or left (0). A cursor move steps the pointer by the R7/R8 rules, right being increment. A display shift left adds one to the offset, a right shift subtracts one, and neither changes the pointer.
- R11: A command with bit 6 as its highest set bit loads its low 6 bits as a glyph-store pointer. A command with bit 7 set loads its low 7 bits as a display-store pointer. Later data accesses go to the store chosen by the latest such command.
- R12: A read request raises `rd_valid` for the one cycle after acceptance, with `rd_data` holding the byte at the pointer before the step.
- R13: While blink is enabled, `blink_phase` toggles every BLINK_CYC cycles. While blink is disabled, it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Engine can take a request |
| in_op | input | 2 | 0 command, 1 data write, 2 data read |
| in_byte | input | 8 | Command code or write data |
| rd_valid | output | 1 | Read result pulse |
| rd_data | output | 8 | Read result byte |
| busy | output | 1 | An operation is in progress |
| addr_ctr | output | 7 | Current store pointer |
| glyph_sel | output | 1 | 1 when data accesses target the glyph store |
| inc_mode | output | 1 | Entry direction, 1 increment |
| wr_shift | output | 1 | Automatic window shift on writes |
| disp_on | output | 1 | Display enable |
| cur_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| two_line | output | 1 | Two-line layout |
| tall_font | output | 1 | Tall glyph format |
| wide_bus | output | 1 | 8-bit host bus flag |
| shift_ofs | output | 7 | Window start column |
| blink_phase | output | 1 | Current blink half-period |
| peek_glyph | input | 1 | Peek selects glyph store |
| peek_idx | input | 7 | Peek physical index |
| peek_data | output | 8 | Peeked byte |

## Verification
A wrong pointer or a wrong line boundary surfaces on `addr_ctr` at the first sample after the accepting edge. The bench compares it there after every request in a scripted sequence that crosses both line seams and the glyph wrap. A misplaced write shows only when the cell is read back, so the peek port is checked at the seams right after the sequence. Errors in the offset or busy length appear on `shift_ofs` or as a wrong count of busy cycles on the very request that caused them. Blink period errors appear within two blink periods.

// File: rtl/lcd_exec_pkg.sv
package lcd_exec_pkg;
  typedef enum logic [1:0] {
    OP_CMD = 2'd0,
    OP_WR  = 2'd1,
    OP_RD  = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_FILL
  } exec_st_e;

  localparam int unsigned CELLS      = 80;
  localparam int unsigned LINE_CELLS = 40;
  localparam int unsigned GLYPH_SZ   = 64;
  localparam logic [7:0]  BLANK      = 8'h20;
endpackage

// File: rtl/lcd_addr_step.sv
module lcd_addr_step (
  input  logic [6:0] cur,
  input  logic       up,
  input  logic       two_line,
  input  logic       glyph,
  output logic [6:0] nxt
);
  always_comb begin
    if (glyph) begin
      nxt = {1'b0, up ? cur[5:0] + 6'd1 : cur[5:0] - 6'd1};
    end else if (!two_line) begin
      if (up) nxt = (cur >= 7'h4F) ? 7'h00 : cur + 7'd1;
      else    nxt = (cur == 7'h00 || cur > 7'h4F) ? 7'h4F : cur - 7'd1;
    end else begin
      if (up) begin
        if (cur == 7'h27)      nxt = 7'h40;
        else if (cur >= 7'h67) nxt = 7'h00;
        else                   nxt = cur + 7'd1;
      end else begin
        if (cur == 7'h00)      nxt = 7'h67;
        else if (cur == 7'h40) nxt = 7'h27;
        else                   nxt = cur - 7'd1;
      end
    end
  end
endmodule

// File: rtl/lcd_blink.sv
module lcd_blink #(
  parameter int unsigned BLINK_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic phase
);
  localparam int unsigned BW = $clog2(BLINK_CYC + 1);
  logic [BW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == BW'(BLINK_CYC - 1)) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_BLINK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !phase); // R13
endmodule

// File: rtl/lcd_exec_core.sv
module lcd_exec_core
  import lcd_exec_pkg::*;
#(
  parameter int unsigned EXEC_CYC  = 4,
  parameter int unsigned BLINK_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_op,
  input  logic [7:0] in_byte,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic [6:0] addr_ctr,
  output logic       glyph_sel,
  output logic       inc_mode,
  output logic       wr_shift,
  output logic       disp_on,
  output logic       cur_on,
  output logic       blink_on,
  output logic       two_line,
  output logic       tall_font,
  output logic       wide_bus,
  output logic [6:0] shift_ofs,
  output logic       blink_phase,
  input  logic       peek_glyph,
  input  logic [6:0] peek_idx,
  output logic [7:0] peek_data
);
  localparam int unsigned CW = $clog2(EXEC_CYC + 1);

  exec_st_e   state;
  logic [CW-1:0] wait_cnt;
  logic [6:0] fill_idx;
  logic [7:0] disp_mem  [CELLS];
  logic [7:0] glyph_mem [GLYPH_SZ];

  logic       accept;
  op_e        op;
  logic [6:0] step_nxt;
  logic       step_up;
  logic [6:0] cell_idx;
  logic       cell_ok;
  logic [6:0] ofs_lim, ofs_left, ofs_right;

  assign op       = op_e'(in_op);
  assign busy     = (state != ST_IDLE);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign step_up  = (op == OP_CMD) ? in_byte[2] : inc_mode;

  lcd_addr_step u_step (
    .cur(addr_ctr), .up(step_up), .two_line(two_line),
    .glyph(glyph_sel), .nxt(step_nxt)
  );

  lcd_blink #(.BLINK_CYC(BLINK_CYC)) u_blink (
    .clk(clk), .rst_n(rst_n), .en(blink_on), .phase(blink_phase)
  );

  always_comb begin
    if (two_line && addr_ctr >= 7'h40) begin
      cell_idx = addr_ctr - 7'd24;
      cell_ok  = addr_ctr < 7'h68;
    end else begin
      cell_idx = addr_ctr;
      cell_ok  = two_line ? (addr_ctr < 7'(LINE_CELLS)) : (addr_ctr < 7'(CELLS));
    end
  end

  assign ofs_lim   = two_line ? 7'(LINE_CELLS - 1) : 7'(CELLS - 1);
  assign ofs_left  = (shift_ofs >= ofs_lim) ? 7'd0 : shift_ofs + 7'd1;
  assign ofs_right = (shift_ofs == 7'd0) ? ofs_lim : shift_ofs - 7'd1;

  always_comb begin
    if (peek_glyph)                 peek_data = glyph_mem[peek_idx[5:0]];
    else if (peek_idx < 7'(CELLS))  peek_data = disp_mem[peek_idx];
    else                            peek_data = 8'h00;
  end

  // store writes
  always_ff @(posedge clk) begin
    if (state == ST_FILL) begin
      disp_mem[fill_idx] <= BLANK;
    end else if (accept && op == OP_WR) begin
      if (glyph_sel)    glyph_mem[addr_ctr[5:0]] <= in_byte;
      else if (cell_ok) disp_mem[cell_idx] <= in_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_FILL;
      fill_idx  <= '0;
      wait_cnt  <= '0;
      addr_ctr  <= '0;
      glyph_sel <= 1'b0;
      inc_mode  <= 1'b1;
      wr_shift  <= 1'b0;
      disp_on   <= 1'b0;
      cur_on    <= 1'b0;
      blink_on  <= 1'b0;
      two_line  <= 1'b0;
      tall_font <= 1'b0;
      wide_bus  <= 1'b1;
      shift_ofs <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        ST_FILL: begin
          if (fill_idx == 7'(CELLS - 1)) begin
            state    <= ST_IDLE;
            fill_idx <= '0;
          end else begin
            fill_idx <= fill_idx + 7'd1;
          end
        end
        ST_WAIT: begin
          if (wait_cnt == '0) state <= ST_IDLE;
          else                wait_cnt <= wait_cnt - 1'b1;
        end
        default: begin
          if (accept) begin
            state    <= ST_WAIT;
            wait_cnt <= CW'(EXEC_CYC - 1);
            case (op)
              OP_WR: begin
                addr_ctr <= step_nxt;
                if (wr_shift && !glyph_sel)
                  shift_ofs <= inc_mode ? ofs_left : ofs_right;
              end
              OP_RD: begin
                rd_valid <= 1'b1;
                if (glyph_sel)    rd_data <= glyph_mem[addr_ctr[5:0]];
                else if (cell_ok) rd_data <= disp_mem[cell_idx];
                else              rd_data <= 8'h00;
                addr_ctr <= step_nxt;
              end
              OP_CMD: begin
                casez (in_byte)
                  8'b1???????: begin
                    addr_ctr  <= in_byte[6:0];
                    glyph_sel <= 1'b0;
                  end
                  8'b01??????: begin
                    addr_ctr  <= {1'b0, in_byte[5:0]};
                    glyph_sel <= 1'b1;
                  end
                  8'b001?????: begin
                    wide_bus  <= in_byte[4];
                    two_line  <= in_byte[3];
                    tall_font <= in_byte[2];
                  end
                  8'b0001????: begin
                    if (in_byte[3]) shift_ofs <= in_byte[2] ? ofs_right : ofs_left;
                    else            addr_ctr  <= step_nxt;
                  end
                  8'b00001???: begin
                    disp_on  <= in_byte[2];
                    cur_on   <= in_byte[1];
                    blink_on <= in_byte[0];
                  end
                  8'b000001??: begin
                    inc_mode <= in_byte[1];
                    wr_shift <= in_byte[0];
                  end
                  8'b0000001?: begin
                    addr_ctr  <= '0;
                    shift_ofs <= '0;
                    glyph_sel <= 1'b0;
                  end
                  8'b00000001: begin
                    state     <= ST_FILL;
                    fill_idx  <= '0;
                    addr_ctr  <= '0;
                    shift_ofs <= '0;
                    glyph_sel <= 1'b0;
                    inc_mode  <= 1'b1;
                  end
                  default: ;
                endcase
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R2
  AST_HOME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_CMD && in_byte[7:2] == 6'd0 && in_byte[1])
      |=> (addr_ctr == 7'd0 && shift_ofs == 7'd0)); // R4
  AST_DSHIFT_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_CMD && in_byte[7:4] == 4'h1 && in_byte[3])
      |=> $stable(addr_ctr)); // R10
  AST_READ_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_RD) |=> ($stable(shift_ofs) && rd_valid)); // R9
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R12
endmodule

// File: tb/test_lcd_exec_core.sv
module test_lcd_exec_core;
  localparam int EXEC_T  = 4;
  localparam int BLINK_T = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_op = 2'd0;
  logic [7:0] in_byte = 8'd0;
  logic peek_glyph = 1'b0;
  logic [6:0] peek_idx = 7'd0;
  logic in_ready, rd_valid, busy, glyph_sel, inc_mode, wr_shift;
  logic disp_on, cur_on, blink_on, two_line, tall_font, wide_bus, blink_phase;
  logic [7:0] rd_data, peek_data;
  logic [6:0] addr_ctr, shift_ofs;

  int checks = 0;
  int errors = 0;
  logic [7:0] last_rd = 8'h00;

  always #2 clk = ~clk;

  lcd_exec_core #(.EXEC_CYC(EXEC_T), .BLINK_CYC(BLINK_T)) i_lcd_exec_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_byte(in_byte), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .addr_ctr(addr_ctr), .glyph_sel(glyph_sel), .inc_mode(inc_mode),
    .wr_shift(wr_shift), .disp_on(disp_on), .cur_on(cur_on), .blink_on(blink_on),
    .two_line(two_line), .tall_font(tall_font), .wide_bus(wide_bus),
    .shift_ofs(shift_ofs), .blink_phase(blink_phase), .peek_glyph(peek_glyph),
    .peek_idx(peek_idx), .peek_data(peek_data)
  );

  // {op, byte, expected pointer afterwards}
  localparam logic [16:0] VEC [17] = '{
    {2'd0, 8'h38, 7'h00},  // R5 two-line
    {2'd0, 8'hA7, 7'h27},  // R11
    {2'd1, 8'h41, 7'h40},  // R8 seam
    {2'd1, 8'h42, 7'h41},
    {2'd0, 8'hE7, 7'h67},
    {2'd1, 8'h43, 7'h00},  // R8 wrap
    {2'd0, 8'h04, 7'h00},
    {2'd1, 8'h44, 7'h67},  // R8 reverse wrap
    {2'd0, 8'hC0, 7'h40},
    {2'd1, 8'h45, 7'h27},  // R8 reverse seam
    {2'd0, 8'h14, 7'h40},  // R10 cursor right
    {2'd0, 8'h10, 7'h27},  // R10 cursor left
    {2'd0, 8'h48, 7'h08},  // R11 glyph
    {2'd1, 8'h1F, 7'h07},  // R6
    {2'd0, 8'h06, 7'h07},
    {2'd0, 8'h7F, 7'h3F},
    {2'd1, 8'h15, 7'h00}   // R6 glyph wrap
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] b, output int bcyc);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_op = op; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
    if (rd_valid) last_rd = rd_data;
    bcyc = 0;
    while (busy) begin bcyc++; @(negedge clk); end
  endtask

  task automatic peek(input logic g, input logic [6:0] idx, output logic [7:0] v);
    peek_glyph = g; peek_idx = idx;
    #1 v = peek_data;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bc;
    int blanks;
    logic [7:0] v;
    logic p;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bc = 0;
    while (busy) begin bc++; @(negedge clk); end
    check("R1 init busy length", bc, 80);
    check("R1 pointer", addr_ctr, 0);
    check("R1 func flags", {wide_bus, two_line, tall_font}, 3'b100);
    check("R1 disp flags", {disp_on, cur_on, blink_on}, 3'b000);
    check("R1 entry", {inc_mode, wr_shift}, 2'b10);
    check("R1 offset", shift_ofs, 0);
    blanks = 0;
    for (int i = 0; i < 80; i++) begin peek(1'b0, 7'(i), v); if (v == 8'h20) blanks++; end
    check("R1 blank cells", blanks, 80);

    foreach (VEC[k]) begin
      send(VEC[k][16:15], VEC[k][14:7], bc);
      check($sformatf("R6/R8/R11 vector %0d pointer", k), addr_ctr, VEC[k][6:0]);
    end
    check("R5 two-line set", two_line, 1);
    peek(1'b0, 7'd39, v); check("R8 cell 0x27", v, 8'h41);
    peek(1'b0, 7'd40, v); check("R8 cell 0x40", v, 8'h45);
    peek(1'b0, 7'd79, v); check("R8 cell 0x67", v, 8'h43);
    peek(1'b0, 7'd0,  v); check("R8 cell 0x00", v, 8'h44);
    peek(1'b1, 7'd8,  v); check("R11 glyph 8", v, 8'h1F);
    peek(1'b1, 7'd63, v); check("R6 glyph 63", v, 8'h15);

    // read path R12
    send(2'd0, 8'h80, bc);
    send(2'd0, 8'h06, bc);
    check("R2 busy length", bc, EXEC_T);
    send(2'd2, 8'h00, bc);
    check("R12 read data", last_rd, 8'h44);
    check("R12 pointer after read", addr_ctr, 1);
    check("R9 read keeps offset", shift_ofs, 0);

    // automatic shift R9
    send(2'd0, 8'h07, bc);
    send(2'd1, 8'h50, bc);
    check("R9 left shift", {shift_ofs, addr_ctr}, {7'd1, 7'd2});
    send(2'd0, 8'h05, bc);
    send(2'd1, 8'h51, bc);
    check("R9 right shift", {shift_ofs, addr_ctr}, {7'd0, 7'd1});
    send(2'd1, 8'h52, bc);
    check("R9 offset wrap", {shift_ofs, addr_ctr}, {7'd39, 7'd0});

    // display shift command R10
    send(2'd0, 8'h18, bc);
    check("R10 display left", {shift_ofs, addr_ctr}, {7'd0, 7'd0});
    send(2'd0, 8'h1C, bc);
    check("R10 display right", {shift_ofs, addr_ctr}, {7'd39, 7'd0});

    // glyph write with auto shift R9
    send(2'd0, 8'h40, bc);
    send(2'd1, 8'h0A, bc);
    check("R9 glyph write no shift", shift_ofs, 39);
    check("R6 glyph decrement wrap", addr_ctr, 7'h3F);

    // home R4
    send(2'd0, 8'h02, bc);
    check("R4 home", {shift_ofs, addr_ctr, glyph_sel}, {7'd0, 7'd0, 1'b0});
    peek(1'b0, 7'd39, v); check("R4 cells kept", v, 8'h41);

    // blink R13, display flags R5
    send(2'd0, 8'h0F, bc);
    check("R5 display flags", {disp_on, cur_on, blink_on}, 3'b111);
    p = blink_phase; n = 0;
    while (blink_phase == p && n < 200) begin n++; @(negedge clk); end
    p = blink_phase; n = 0;
    while (blink_phase == p && n < 200) begin n++; @(negedge clk); end
    check("R13 blink period", n, BLINK_T);
    send(2'd0, 8'h0C, bc);
    check("R2 busy length display", bc, EXEC_T);
    check("R13 blink off phase", blink_phase, 0);

    // one-line map R7
    send(2'd0, 8'h30, bc);
    check("R5 one-line", {wide_bus, two_line, tall_font}, 3'b100);
    send(2'd0, 8'h06, bc);
    send(2'd0, 8'hCF, bc);
    send(2'd1, 8'h77, bc);
    check("R7 wrap up", addr_ctr, 0);
    send(2'd0, 8'h04, bc);
    send(2'd1, 8'h78, bc);
    check("R7 wrap down", addr_ctr, 7'h4F);
    peek(1'b0, 7'h4F, v); check("R7 cell 0x4F", v, 8'h77);
    peek(1'b0, 7'h00, v); check("R7 cell 0x00", v, 8'h78);

    // clear R3
    send(2'd0, 8'h1C, bc);
    send(2'd0, 8'h01, bc);
    check("R3 clear busy", bc, 80);
    check("R3 state", {addr_ctr, shift_ofs, inc_mode, glyph_sel}, {7'd0, 7'd0, 1'b1, 1'b0});
    blanks = 0;
    for (int i = 0; i < 80; i++) begin peek(1'b0, 7'(i), v); if (v == 8'h20) blanks++; end
    check("R3 blank cells", blanks, 80);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule